// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link. A client hands it one command at a time on a valid/ready request port. The command carries an operation code, a 7-bit word address and 16 bits of write data. The block derives the serial clock from the system clock through a counter. It shifts out the start bit, opcode and address, plus the data word for the two write commands, with the exact number of serial clock pulses each command needs. It captures returned bits from the device and reports the result on a single-cycle response strobe.

For the four programming commands (single-word write, single-word erase, erase-all, write-all), the block ends the frame by lowering chip select. This starts the self-timed cycle inside the device. The block keeps chip select low for the minimum deselect time, raises it again, and waits for the status output to settle. It then samples the device output every system cycle until the device reports ready. If the device is still busy when a parameterized limit expires, the transaction ends with an error flag. Every timing figure is given in nanoseconds and converted to a whole number of system cycles by rounding up.

Top module: `mw_eeprom_host`

## Requirements
- R1: After reset, chip select and the serial clock are low, reqReady is high and rspValid is low.
- R2: Each frame is sent MSB first: a 1 start bit, a 2-bit opcode, then the 7-bit address. The opcodes are read 10, write 01 and erase 11. reqOp selects the command: 0 read, 1 write, 2 erase, 3 write-enable, 4 write-disable, 5 erase-all, 6 write-all. The last four send opcode 00 with a sub-code in the two top address bit positions: write-enable 11, write-disable 00, erase-all 10, write-all 01. The remaining five address bits of these four commands are sent as zeros. Write and write-all then send the 16 data bits MSB first.
- R3: While chip select is high, the serial clock makes exactly 10 rising edges for erase, write-enable, write-disable and erase-all, 26 for write and write-all, and 27 for read. The serial clock never rises while chip select is low.
- R4: The serial data output changes only while the serial clock is low. Every high phase and every low phase of the serial clock lasts at least HALF_CYC system cycles. HALF_CYC is the larger of CLK_DIV and 250 ns rounded up to whole cycles.
- R5: Chip select rises while the serial clock is low and leads the first rising edge by at least 50 ns worth of cycles.
- R6: For read, the bit that follows the address is discarded. The next 16 bits are returned on rspData MSB first, each sampled just before the following rising edge.
- R7: After a programming command, the block lowers chip select, holds it low, raises it again and waits 500 ns worth of cycles. It then samples the device output until the output is high, and responds with rspErr low.
- R8: If the device output stays low for TIMEOUT_US (in system cycles, rounded up) after the poll phase begins, the block ends the poll and responds with rspErr high.
- R9: Every low period of chip select lasts at least 250 ns worth of cycles. reqReady stays low from acceptance until the response, including the final deselect gap.
- R10: rspValid is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Command request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqOp | input | 3 | Command code (see R2) |
| reqAddr | input | 7 | Word address |
| reqData | input | 16 | Write data for write and write-all |
| rspValid | output | 1 | One-cycle completion strobe |
| rspData | output | 16 | Read word, valid with rspValid after a read |
| rspErr | output | 1 | Busy-poll timeout, valid with rspValid |
| eeCs | output | 1 | Chip select to the device |
| eeClk | output | 1 | Serial clock to the device |
| eeDi | output | 1 | Serial data to the device |
| eeDo | input | 1 | Serial data and ready status from the device |

## Verification
The assertions assume that reqOp is held steady while reqValid is high. They also assume that eeDo is driven to a definite level whenever it is sampled, which means during the read data bits and during the poll window. The bench holds the request fields steady until the accepting edge. Its behavioral device model always drives eeDo with a known level: the read bit while a read is in progress, and otherwise the ready or busy status. The model changes eeDo only on a serial clock rising edge or on a system edge, so the host samples a settled value.

// File: rtl/mw_host_pkg.sv
package mw_host_pkg;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_WREN      = 3'd3,
    OP_WRDIS     = 3'd4,
    OP_ERASE_ALL = 3'd5,
    OP_WRITE_ALL = 3'd6
  } mwOp_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_LOW, S_HIGH, S_GAP, S_STAT, S_POLL, S_DONE
  } ctrlState_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
  } dpStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mw_host_dp.sv
module mw_host_dp
  import mw_host_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int HDR_W  = 3 + ADDR_W,
  parameter int CNT_W  = $clog2(HDR_W + DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              eeDo,
  output logic              eeDi,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  frameLen,
  output logic              isRead,
  output logic              isProg
);

  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int PAD_W   = ADDR_W - 2;

  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  rxShift;
  logic [2:0]         opQ;
  logic [1:0]         opcNext;
  logic [ADDR_W-1:0]  addrNext;
  logic               hasData;

  always_comb begin
    opcNext  = 2'b00;
    addrNext = reqAddr;
    unique case (reqOp)
      OP_READ:      opcNext = 2'b10;
      OP_WRITE:     opcNext = 2'b01;
      OP_ERASE:     opcNext = 2'b11;
      OP_WREN:      addrNext = {2'b11, {PAD_W{1'b0}}};
      OP_WRDIS:     addrNext = {2'b00, {PAD_W{1'b0}}};
      OP_ERASE_ALL: addrNext = {2'b10, {PAD_W{1'b0}}};
      OP_WRITE_ALL: addrNext = {2'b01, {PAD_W{1'b0}}};
      default:      addrNext = reqAddr;
    endcase
    hasData = (reqOp == OP_WRITE) || (reqOp == OP_WRITE_ALL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShift <= '0;
      rxShift <= '0;
      opQ     <= OP_WRDIS;
    end else begin
      if (strobe.load) begin
        txShift <= {1'b1, opcNext, addrNext, (hasData ? reqData : {DATA_W{1'b0}})};
        opQ     <= reqOp;
      end else if (strobe.advance) begin
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      end
      if (strobe.capture) rxShift <= {rxShift[DATA_W-2:0], eeDo};
    end
  end

  always_comb begin
    isRead = (opQ == OP_READ);
    isProg = (opQ == OP_WRITE) || (opQ == OP_ERASE) ||
             (opQ == OP_ERASE_ALL) || (opQ == OP_WRITE_ALL);
    if (isRead)
      frameLen = CNT_W'(FRAME_W + 1);
    else if ((opQ == OP_WRITE) || (opQ == OP_WRITE_ALL))
      frameLen = CNT_W'(FRAME_W);
    else
      frameLen = CNT_W'(HDR_W);
  end

  assign eeDi   = txShift[FRAME_W-1];
  assign rdData = rxShift;

endmodule

// File: rtl/mw_host_ctrl.sv
module mw_host_ctrl
  import mw_host_pkg::*;
#(
  parameter int HALF_CYC    = 32,
  parameter int SETUP_CYC   = 7,
  parameter int GAP_CYC     = 32,
  parameter int STAT_CYC    = 63,
  parameter int TIMEOUT_CYC = 2500,
  parameter int CNT_W       = 5,
  parameter int CAP_START   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  output logic             reqReady,
  output logic             rspValid,
  output logic             rspErr,
  output logic             eeCs,
  output logic             eeClk,
  input  logic             eeDo,
  input  logic [CNT_W-1:0] frameLen,
  input  logic             isRead,
  input  logic             isProg,
  output dpStrobe_t        strobe
);

  localparam int TMR_MAX = maxOf(maxOf(HALF_CYC, SETUP_CYC), maxOf(GAP_CYC, STAT_CYC));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int TO_W    = $clog2(TIMEOUT_CYC + 1);

  ctrlState_e       state;
  logic [TMR_W-1:0] tmr;
  logic [TO_W-1:0]  tout;
  logic [CNT_W-1:0] bitIdx;
  logic             pollPend;
  logic             errQ;
  logic             csQ;
  logic             clkQ;
  logic             halfEnd;
  logic             lastBit;

  assign halfEnd = (tmr == TMR_W'(HALF_CYC - 1));
  assign lastBit = ((bitIdx + 1'b1) == frameLen);

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == S_IDLE) && reqValid;
    strobe.capture = (state == S_LOW) && halfEnd && isRead &&
                     (bitIdx >= CNT_W'(CAP_START));
    strobe.advance = (state == S_HIGH) && halfEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tmr      <= '0;
      tout     <= '0;
      bitIdx   <= '0;
      pollPend <= 1'b0;
      errQ     <= 1'b0;
      csQ      <= 1'b0;
      clkQ     <= 1'b0;
    end else begin
      tmr <= tmr + 1'b1;
      unique case (state)
        S_IDLE: begin
          tmr <= '0;
          if (reqValid) begin
            state  <= S_SETUP;
            csQ    <= 1'b1;
            bitIdx <= '0;
            errQ   <= 1'b0;
          end
        end
        S_SETUP: if (tmr == TMR_W'(SETUP_CYC - 1)) begin
          state <= S_LOW;
          tmr   <= '0;
        end
        S_LOW: if (halfEnd) begin
          state <= S_HIGH;
          clkQ  <= 1'b1;
          tmr   <= '0;
        end
        S_HIGH: if (halfEnd) begin
          clkQ   <= 1'b0;
          tmr    <= '0;
          bitIdx <= bitIdx + 1'b1;
          if (lastBit) begin
            state    <= S_GAP;
            csQ      <= 1'b0;
            pollPend <= isProg;
          end else begin
            state <= S_LOW;
          end
        end
        S_GAP: if (tmr == TMR_W'(GAP_CYC - 1)) begin
          tmr <= '0;
          if (pollPend) begin
            state <= S_STAT;
            csQ   <= 1'b1;
            tout  <= '0;
          end else begin
            state <= S_DONE;
          end
        end
        S_STAT: begin
          tout <= tout + 1'b1;
          if (tmr == TMR_W'(STAT_CYC - 1)) state <= S_POLL;
        end
        S_POLL: begin
          tout <= tout + 1'b1;
          if (eeDo || (tout >= TO_W'(TIMEOUT_CYC - 1))) begin
            errQ     <= !eeDo;
            csQ      <= 1'b0;
            pollPend <= 1'b0;
            tmr      <= '0;
            state    <= S_GAP;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_DONE);
  assign rspErr   = (state == S_DONE) && errQ;
  assign eeCs     = csQ;
  assign eeClk    = clkQ;

endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_host_pkg::*;
#(
  parameter int SYS_PERIOD_NS = 8,
  parameter int CLK_DIV       = 32,
  parameter int TIMEOUT_US    = 20000,
  parameter int ADDR_W        = 7,
  parameter int DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr,
  output logic              eeCs,
  output logic              eeClk,
  output logic              eeDi,
  input  logic              eeDo
);

  localparam int HALF_CYC    = maxOf(CLK_DIV, ceilDiv(250, SYS_PERIOD_NS));
  localparam int SETUP_CYC   = maxOf(ceilDiv(50, SYS_PERIOD_NS), 1);
  localparam int GAP_CYC     = ceilDiv(250, SYS_PERIOD_NS);
  localparam int STAT_CYC    = ceilDiv(500, SYS_PERIOD_NS);
  localparam int TIMEOUT_CYC = ceilDiv(TIMEOUT_US * 1000, SYS_PERIOD_NS);
  localparam int HDR_W       = 3 + ADDR_W;
  localparam int CNT_W       = $clog2(HDR_W + DATA_W + 2);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] frameLen;
  logic             isRead;
  logic             isProg;

  mw_host_ctrl #(
    .HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC), .GAP_CYC(GAP_CYC),
    .STAT_CYC(STAT_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W),
    .CAP_START(HDR_W + 1)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspErr(rspErr), .eeCs(eeCs), .eeClk(eeClk),
    .eeDo(eeDo), .frameLen(frameLen), .isRead(isRead), .isProg(isProg),
    .strobe(strobe)
  );

  mw_host_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HDR_W(HDR_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .eeDo(eeDo), .eeDi(eeDi),
    .rdData(rspData), .frameLen(frameLen), .isRead(isRead), .isProg(isProg)
  );

endmodule

// File: rtl/mw_host_chk.sv
module mw_host_chk #(
  parameter int HALF_CYC = 32,
  parameter int GAP_CYC  = 32
) (
  input logic clk,
  input logic rst_n,
  input logic reqReady,
  input logic rspValid,
  input logic eeCs,
  input logic eeClk,
  input logic eeDi
);

  int highRun;
  int lowRun;
  int csLowRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      highRun  <= 0;
      lowRun   <= HALF_CYC;
      csLowRun <= GAP_CYC;
    end else begin
      highRun  <= eeClk ? highRun + 1 : 0;
      lowRun   <= eeClk ? 0 : ((lowRun < HALF_CYC) ? lowRun + 1 : lowRun);
      csLowRun <= eeCs ? 0 : ((csLowRun < GAP_CYC) ? csLowRun + 1 : csLowRun);
    end
  end

  // R4: data into the device holds while the serial clock is high
  assert_di_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eeClk |-> $stable(eeDi));

  // R4: high phase width
  assert_high_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eeClk) |-> highRun >= HALF_CYC);

  // R4: low phase width
  assert_low_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eeClk) |-> lowRun >= HALF_CYC);

  // R3: no serial clock while deselected
  assert_clk_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eeCs |-> !eeClk);

  // R5: chip select rises with the clock low
  assert_cs_rise_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eeCs) |-> !eeClk);

  // R9: deselect gap
  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eeCs) |-> csLowRun >= GAP_CYC);

  // R9: no new request while the device is selected
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eeCs |-> !reqReady);

  // R10: single-cycle response
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

endmodule

bind mw_eeprom_host mw_host_chk #(.HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .reqReady(reqReady), .rspValid(rspValid),
  .eeCs(eeCs), .eeClk(eeClk), .eeDi(eeDi)
);

// File: tb/mw_eeprom_host_tb.sv
module mw_eeprom_host_tb_top;

  localparam int BUSY_CYC    = 800;
  localparam int TIMEOUT_CYC = (20 * 1000 + 7) / 8;
  localparam int HALF_EXP    = 32;
  localparam int SETUP_EXP   = 7;
  localparam int GAP_EXP     = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqOp = 3'd0;
  logic [6:0]  reqAddr = 7'd0;
  logic [15:0] reqData = 16'd0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        rspErr;
  logic        eeCs, eeClk, eeDi, eeDo;

  always #4 clk = ~clk;

  mw_eeprom_host #(.SYS_PERIOD_NS(8), .CLK_DIV(32), .TIMEOUT_US(20)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .rspValid(rspValid),
    .rspData(rspData), .rspErr(rspErr), .eeCs(eeCs), .eeClk(eeClk),
    .eeDi(eeDi), .eeDo(eeDo)
  );

  // ---------------- device model ----------------
  logic [15:0] mem [128];
  logic        wen = 1'b0;
  logic        stuck = 1'b0;
  int          busyCnt = 0;
  int          gen = 0, seenGen = -1, decGen = -1;
  int          nb = 0, lastNb = 0, pollSeen = 0, startBad = 0;
  logic [26:0] sh = '0;
  logic [9:0]  lastHdr = '0;
  logic        reading = 1'b0, rdBit = 1'b0, prevCs = 1'b0;
  logic [6:0]  rdAddr = '0;
  int          rdIdx = 0;

  assign eeDo = (reading && seenGen == gen) ? rdBit : (busyCnt == 0 && !stuck);

  always @(posedge eeClk) if (eeCs) begin
    if (seenGen != gen) begin nb = 0; seenGen = gen; reading = 1'b0; end
    sh = {sh[25:0], eeDi};
    nb++;
    if (nb == 1 && !eeDi) startBad++;
    if (reading) begin
      rdBit = (rdIdx < 16) ? mem[rdAddr][15 - rdIdx] : 1'b0;
      rdIdx++;
    end
    if (nb == 10 && sh[8:7] == 2'b10) begin
      reading = 1'b1; rdAddr = sh[6:0]; rdIdx = 0; rdBit = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (busyCnt > 0) busyCnt--;
    if (eeCs && !prevCs) begin
      gen++;
      if (busyCnt > 0 || stuck) pollSeen++;
    end
    if (!eeCs && prevCs && seenGen == gen && decGen != gen) begin
      logic [9:0]  hdr;
      logic [15:0] dat;
      decGen = gen;
      lastNb = nb;
      hdr = (nb == 26) ? sh[25:16] : sh[9:0];
      dat = sh[15:0];
      lastHdr = hdr;
      if (hdr[8:7] == 2'b11 && nb == 10 && wen) begin
        mem[hdr[6:0]] = 16'hFFFF; busyCnt = BUSY_CYC;
      end else if (hdr[8:7] == 2'b01 && nb == 26 && wen) begin
        mem[hdr[6:0]] = dat; busyCnt = BUSY_CYC;
      end else if (hdr[8:7] == 2'b00) begin
        case (hdr[6:5])
          2'b11: if (nb == 10) wen = 1'b1;
          2'b00: if (nb == 10) wen = 1'b0;
          2'b10: if (nb == 10 && wen) begin
            for (int i = 0; i < 128; i++) mem[i] = 16'hFFFF;
            busyCnt = BUSY_CYC;
          end
          default: if (nb == 26 && wen) begin
            for (int i = 0; i < 128; i++) mem[i] = dat;
            busyCnt = BUSY_CYC;
          end
        endcase
      end
    end
    prevCs = eeCs;
  end

  // ---------------- timing monitors (sampled at negedge) ----------------
  int hiRun = 0, loRun = 0, csHiRun = 0, csLoRun = 0, rvRun = 0;
  int minHigh = 1000, minLow = 1000, minSetup = 1000, minGap = 1000, maxRv = 0;
  int diViol = 0, clkNoCs = 0;
  logic pClk = 1'b0, pCs = 1'b0, pDi = 1'b0, firstRise = 1'b0, seenCs = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (eeClk && pClk && eeDi != pDi) diViol++;
    if (eeClk && !eeCs) clkNoCs++;
    if (eeClk) hiRun++; else if (pClk) begin
      if (hiRun < minHigh) minHigh = hiRun; hiRun = 0;
    end
    if (eeCs && !eeClk) loRun++;
    if (eeClk && !pClk) begin
      if (loRun < minLow) minLow = loRun; loRun = 0;
      if (firstRise) begin
        if (csHiRun < minSetup) minSetup = csHiRun; firstRise = 1'b0;
      end
    end
    if (eeCs && !pCs) begin
      firstRise = 1'b1; csHiRun = 0;
      if (seenCs && csLoRun < minGap) minGap = csLoRun;
      seenCs = 1'b1;
    end
    if (eeCs) csHiRun++;
    if (!eeCs) csLoRun++; else csLoRun = 0;
    if (rspValid) rvRun++; else rvRun = 0;
    if (rvRun > maxRv) maxRv = rvRun;
    pClk = eeClk; pCs = eeCs; pDi = eeDi;
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [15:0] lastData;
  logic lastErr, midReady;
  int lastLat;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [2:0] op, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    midReady = reqReady;
    lastLat = 0;
    while (!rspValid) begin @(negedge clk); lastLat++; end
    lastData = rspData; lastErr = rspErr;
  endtask

  task automatic testReset;
    chk(eeCs == 1'b0, "R1 cs", int'(eeCs), 0);
    chk(eeClk == 1'b0, "R1 clk", int'(eeClk), 0);
    chk(reqReady == 1'b1, "R1 ready", int'(reqReady), 1);
    chk(rspValid == 1'b0, "R1 rspValid", int'(rspValid), 0);
  endtask

  task automatic testEnable;
    doReq(3'd3, 7'h55, 16'h0);
    chk(lastNb == 10, "R3 enable rises", lastNb, 10);
    chk(lastHdr == 10'b1_00_11_00000, "R2 enable frame", int'(lastHdr), 10'b1_00_11_00000);
    chk(midReady == 1'b0, "R9 ready low while active", int'(midReady), 0);
  endtask

  task automatic testWriteRead(input logic [6:0] a, input logic [15:0] d);
    int p0;
    p0 = pollSeen;
    doReq(3'd1, a, d);
    chk(lastNb == 26, "R3 write rises", lastNb, 26);
    chk(mem[a] == d, "R2 write data", int'(mem[a]), int'(d));
    chk(lastErr == 1'b0, "R7 write no error", int'(lastErr), 0);
    chk(pollSeen == p0 + 1 && lastLat >= BUSY_CYC, "R7 polled until ready", lastLat, BUSY_CYC);
    doReq(3'd0, a, 16'h0);
    chk(lastNb == 27, "R3 read rises", lastNb, 27);
    chk(lastData == d, "R6 read data", int'(lastData), int'(d));
  endtask

  task automatic testErase;
    doReq(3'd2, 7'h05, 16'h0);
    chk(lastHdr == 10'b1_11_0000101, "R2 erase frame", int'(lastHdr), 10'b1_11_0000101);
    doReq(3'd0, 7'h05, 16'h0);
    chk(lastData == 16'hFFFF, "R6 read erased", int'(lastData), 16'hFFFF);
  endtask

  task automatic testWriteAll;
    doReq(3'd6, 7'h00, 16'h1234);
    chk(lastHdr == 10'b1_00_01_00000, "R2 write-all frame", int'(lastHdr), 10'b1_00_01_00000);
    doReq(3'd0, 7'h40, 16'h0);
    chk(lastData == 16'h1234, "R6 read after write-all", int'(lastData), 16'h1234);
    doReq(3'd5, 7'h00, 16'h0);
    chk(lastNb == 10 && mem[7'h22] == 16'hFFFF, "R2 erase-all", int'(mem[7'h22]), 16'hFFFF);
  endtask

  task automatic testDisable;
    doReq(3'd4, 7'h7F, 16'h0);
    chk(lastHdr == 10'b1_00_00_00000, "R2 disable frame", int'(lastHdr), 0);
    doReq(3'd1, 7'h03, 16'h0000);
    doReq(3'd0, 7'h03, 16'h0);
    chk(lastData == 16'hFFFF, "R2 write blocked after disable", int'(lastData), 16'hFFFF);
  endtask

  task automatic testTimeout;
    doReq(3'd3, 7'h0, 16'h0);
    stuck = 1'b1;
    doReq(3'd1, 7'h10, 16'hBEEF);
    chk(lastErr == 1'b1, "R8 timeout error", int'(lastErr), 1);
    chk(lastLat >= TIMEOUT_CYC, "R8 timeout duration", lastLat, TIMEOUT_CYC);
    stuck = 1'b0;
    doReq(3'd2, 7'h10, 16'h0);
    chk(lastErr == 1'b0, "R7 recovery no error", int'(lastErr), 0);
  endtask

  task automatic testTiming;
    chk(diViol == 0, "R4 data stable while clock high", diViol, 0);
    chk(minHigh >= HALF_EXP, "R4 high width", minHigh, HALF_EXP);
    chk(minLow >= HALF_EXP, "R4 low width", minLow, HALF_EXP);
    chk(minSetup >= SETUP_EXP, "R5 cs setup", minSetup, SETUP_EXP);
    chk(minGap >= GAP_EXP, "R9 cs gap", minGap, GAP_EXP);
    chk(maxRv == 1, "R10 response pulse width", maxRv, 1);
    chk(clkNoCs == 0 && startBad == 0, "R3 clock only with cs, R2 start bit", clkNoCs + startBad, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testEnable();
    testWriteRead(7'h05, 16'hA5C3);
    testWriteRead(7'h7F, 16'h0001);
    testErase();
    testWriteAll();
    testDisable();
    testTimeout();
    testTiming();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule